// File: doc/BRIEF.md
# Best Fit Sequential Search Unit

This block picks the closest stored figure from a set of candidates that share one result bus. During a scan it raises one select line per cycle. Source 0 is a threshold register and sources 1 to NUM_LOC are stored-figure locations. For each source it reads back a fit value and a name, and it keeps the lowest fit seen together with that fit's name. A location whose name is zero is treated as erased and never wins.

A recognition pass is made of NUM_VIEWS scans, one per rotated view. The first scan of a pass seeds the result from the threshold. Later scans only try to improve on the best value carried over from earlier views. When the last view is done, the kept fit is sent out serially: a down counter is loaded with the fit and gives one pulse per clock. The name is presented in parallel, and a done flag follows the burst.

A separate store mode turns the scan off. It selects one location chosen from outside and takes that location's fit and name as they are. It then sends that fit out the same way, so a freshly stored figure can be shown.

Top module: `best_fit_search`

## Requirements
- R1: After reset, all select lines are low, the pulse line is low, the done flag is low, and the best fit and the best name read zero.
- R2: A scan raises exactly one select line per cycle, in ascending source order (bit k of `src_sel_o` selects source k). A first-view scan covers sources 0 to NUM_LOC. A later-view scan covers sources 1 to NUM_LOC.
- R3: On a scan started with `first_view_i` high, the fit from source 0 becomes the best fit whatever its value. The best name becomes the reserved code all-ones (4'hF), which means no figure was recognized.
- R4: A location replaces the kept best only when its fit is strictly lower than the kept fit and its name is non-zero. Equal fits and erased locations (name 0) leave the result unchanged.
- R5: On a scan started with `first_view_i` low, source 0 is never selected. The best fit and name kept from earlier views are carried forward.
- R6: After the NUM_VIEWS-th scan since the last first-view start, `pulse_o` gives exactly as many single-cycle pulses as the final best fit. There is one pulse per clock, and pulses only occur after that final scan.
- R7: `done_o` rises only after the last pulse of a burst, stays high while idle, and clears on the next start. A final best fit of zero gives no pulses and still raises done.
- R8: While idle with `store_mode_i` high, only the select line given by `store_sel_i` is raised. A start captures that location's fit and name with no comparison, even a larger fit or a zero name. The captured fit is then sent as a pulse burst, followed by done.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a scan, or a store capture in store mode, when idle |
| first_view_i | input | 1 | Sampled with start: this scan is the first view of a pass |
| store_mode_i | input | 1 | Selects store mode (direct capture) instead of search |
| store_sel_i | input | IDX_W | Location index used in store mode |
| bus_fit_i | input | FIT_W | Fit value from the selected source |
| bus_name_i | input | NAME_W | Name from the selected source |
| src_sel_o | output | NUM_LOC+1 | One-hot source select |
| best_fit_o | output | FIT_W | Kept lowest fit |
| best_name_o | output | NAME_W | Name of the kept fit, all-ones if the threshold won |
| pulse_o | output | 1 | Serial fit burst, one pulse per clock |
| done_o | output | 1 | Burst finished |

## Verification
The bench builds the block with NUM_VIEWS set to 3 and keeps NUM_LOC at 5, FIT_W at 16 and NAME_W at 4. Three views are enough to exercise a first view, a carried-over middle view and a final view that triggers the burst, and each pass stays a few dozen cycles long. With fits kept below a few hundred, every burst can be counted pulse by pulse, including a zero-length burst. The store-mode capture of a fit larger than the kept best also stays short.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_LOAD  = 2'd2,
        ST_BURST = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic valid;      // a source is being read this cycle
        logic src0;       // the source read is the threshold
        logic store_cap;  // direct capture in store mode
        logic load;       // load the burst counter from the kept fit
        logic in_burst;   // burst counter running
    } scan_ctl_t;

endpackage

// File: rtl/bfs_sequencer.sv
module bfs_sequencer
    import bfs_pkg::*;
#(
    parameter int NUM_LOC   = 5,
    parameter int NUM_VIEWS = 18,
    parameter int NSRC      = NUM_LOC + 1,
    parameter int IDX_W     = $clog2(NSRC),
    parameter int VCNT_W    = $clog2(NUM_VIEWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             first_view_i,
    input  logic             store_mode_i,
    input  logic [IDX_W-1:0] store_sel_i,
    input  logic             cnt_zero_i,
    output logic [NSRC-1:0]  sel_o,
    output scan_ctl_t        ctl_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_LOC);
    localparam logic [VCNT_W-1:0] LAST_VIEW = VCNT_W'(NUM_VIEWS - 1);

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [VCNT_W-1:0] vcnt;
    logic [IDX_W-1:0]  target;
    logic              sel_en;

    always_comb begin
        target = (state == ST_SCAN) ? idx : store_sel_i;
        sel_en = (state == ST_SCAN) || ((state == ST_IDLE) && store_mode_i);
        sel_o  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel_en && (target == IDX_W'(i))) sel_o[i] = 1'b1;
        end
    end

    always_comb begin
        ctl_o.valid     = (state == ST_SCAN);
        ctl_o.src0      = (state == ST_SCAN) && (idx == '0);
        ctl_o.store_cap = (state == ST_IDLE) && start_i && store_mode_i;
        ctl_o.load      = (state == ST_LOAD);
        ctl_o.in_burst  = (state == ST_BURST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            vcnt   <= '0;
            done_o <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        done_o <= 1'b0;
                        if (store_mode_i) begin
                            state <= ST_LOAD;
                        end else begin
                            state <= ST_SCAN;
                            idx   <= first_view_i ? '0 : IDX_W'(1);
                            if (first_view_i) vcnt <= '0;
                        end
                    end
                end
                ST_SCAN: begin
                    if (idx == LAST_IDX) begin
                        if (vcnt == LAST_VIEW) begin
                            vcnt  <= '0;
                            state <= ST_LOAD;
                        end else begin
                            vcnt  <= vcnt + 1'b1;
                            state <= ST_IDLE;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_LOAD: state <= ST_BURST;
                ST_BURST: begin
                    if (cnt_zero_i) begin
                        done_o <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bfs_best_keep.sv
module bfs_best_keep
    import bfs_pkg::*;
#(
    parameter int              FIT_W     = 16,
    parameter int              NAME_W    = 4,
    parameter logic [NAME_W-1:0] NAME_NONE = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  scan_ctl_t         ctl_i,
    input  logic [FIT_W-1:0]  bus_fit_i,
    input  logic [NAME_W-1:0] bus_name_i,
    output logic [FIT_W-1:0]  best_fit_o,
    output logic [NAME_W-1:0] best_name_o
);
    logic better;

    always_comb begin
        better = (bus_name_i != '0) && (bus_fit_i < best_fit_o);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            best_fit_o  <= '0;
            best_name_o <= '0;
        end else if (ctl_i.store_cap) begin
            best_fit_o  <= bus_fit_i;
            best_name_o <= bus_name_i;
        end else if (ctl_i.valid && ctl_i.src0) begin
            best_fit_o  <= bus_fit_i;
            best_name_o <= NAME_NONE;
        end else if (ctl_i.valid && better) begin
            best_fit_o  <= bus_fit_i;
            best_name_o <= bus_name_i;
        end
    end
endmodule

// File: rtl/bfs_pulse_out.sv
module bfs_pulse_out #(
    parameter int FIT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [FIT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             pulse_o,
    output logic             zero_o
);
    logic [FIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                      cnt <= '0;
        else if (load_i)              cnt <= load_val_i;
        else if (run_i && cnt != '0)  cnt <= cnt - 1'b1;
    end

    always_comb begin
        zero_o  = (cnt == '0);
        pulse_o = run_i && !zero_o;
    end
endmodule

// File: rtl/best_fit_search.sv
module best_fit_search
    import bfs_pkg::*;
#(
    parameter int FIT_W     = 16,
    parameter int NAME_W    = 4,
    parameter int NUM_LOC   = 5,
    parameter int NUM_VIEWS = 18,
    localparam int NSRC     = NUM_LOC + 1,
    localparam int IDX_W    = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              first_view_i,
    input  logic              store_mode_i,
    input  logic [IDX_W-1:0]  store_sel_i,
    input  logic [FIT_W-1:0]  bus_fit_i,
    input  logic [NAME_W-1:0] bus_name_i,
    output logic [NSRC-1:0]   src_sel_o,
    output logic [FIT_W-1:0]  best_fit_o,
    output logic [NAME_W-1:0] best_name_o,
    output logic              pulse_o,
    output logic              done_o
);
    localparam logic [NAME_W-1:0] NAME_NONE = {NAME_W{1'b1}};

    scan_ctl_t ctl;
    logic      cnt_zero;

    bfs_sequencer #(
        .NUM_LOC  (NUM_LOC),
        .NUM_VIEWS(NUM_VIEWS)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .first_view_i(first_view_i),
        .store_mode_i(store_mode_i),
        .store_sel_i (store_sel_i),
        .cnt_zero_i  (cnt_zero),
        .sel_o       (src_sel_o),
        .ctl_o       (ctl),
        .done_o      (done_o)
    );

    bfs_best_keep #(
        .FIT_W    (FIT_W),
        .NAME_W   (NAME_W),
        .NAME_NONE(NAME_NONE)
    ) keep_i (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (ctl),
        .bus_fit_i  (bus_fit_i),
        .bus_name_i (bus_name_i),
        .best_fit_o (best_fit_o),
        .best_name_o(best_name_o)
    );

    bfs_pulse_out #(
        .FIT_W(FIT_W)
    ) out_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (ctl.load),
        .load_val_i(best_fit_o),
        .run_i     (ctl.in_burst),
        .pulse_o   (pulse_o),
        .zero_o    (cnt_zero)
    );
endmodule

// File: rtl/best_fit_search_chk.sv
module best_fit_search_chk #(
    parameter int NSRC   = 6,
    parameter int FIT_W  = 16,
    parameter int NAME_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   sel,
    input logic [FIT_W-1:0]  best_fit,
    input logic [NAME_W-1:0] best_name,
    input logic              pulse,
    input logic              done,
    input logic              store_cap,
    input logic              thr_load,
    input logic              in_burst
);
    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R4
    fit_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(thr_load) && !$past(store_cap)) |-> (best_fit <= $past(best_fit)));

    // R4
    name_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(store_cap) && (best_name != $past(best_name))) |-> (best_name != '0));

    // R6
    pulse_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> in_burst);

    // R7
    pulse_not_done_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> !done);

    // R7
    done_after_burst_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(in_burst));
endmodule

bind best_fit_search best_fit_search_chk #(
    .NSRC  (NUM_LOC + 1),
    .FIT_W (FIT_W),
    .NAME_W(NAME_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .sel      (src_sel_o),
    .best_fit (best_fit_o),
    .best_name(best_name_o),
    .pulse    (pulse_o),
    .done     (done_o),
    .store_cap(ctl.store_cap),
    .thr_load (ctl.src0),
    .in_burst (ctl.in_burst)
);

// File: tb/best_fit_search_tb_top.sv
module best_fit_search_tb_top;
    localparam int FIT_W = 16;
    localparam int NAME_W = 4;
    localparam int NUM_LOC = 5;
    localparam int NUM_VIEWS = 3;
    localparam int NSRC = NUM_LOC + 1;
    localparam int IDX_W = $clog2(NSRC);
    localparam logic [NAME_W-1:0] NONE = 4'hF;

    typedef struct packed {
        logic                   first;
        logic                   last;
        logic [5:0][FIT_W-1:0]  fit;   // index 5 written leftmost
        logic [5:0][NAME_W-1:0] name;
        logic [FIT_W-1:0]       exp_fit;
        logic [NAME_W-1:0]      exp_name;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        // pass A: tie kept, erased ignored, carried best wins
        '{1'b1, 1'b0, {16'd90, 16'd30, 16'd70, 16'd30, 16'd50, 16'd100}, {4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, 16'd30, 4'd2},
        '{1'b0, 1'b0, {16'd10, 16'd80, 16'd25, 16'd60, 16'd40, 16'd5},   {4'd0, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, 16'd25, 4'd3},
        '{1'b0, 1'b1, {16'd29, 16'd25, 16'd28, 16'd27, 16'd26, 16'd1},   {4'd10, 4'd9, 4'd8, 4'd7, 4'd6, 4'd0}, 16'd25, 4'd3},
        // pass B: threshold survives all views
        '{1'b1, 1'b0, {16'd60, 16'd50, 16'd40, 16'd30, 16'd20, 16'd20},  {4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, 16'd20, NONE},
        '{1'b0, 1'b0, {16'd25, 16'd24, 16'd23, 16'd22, 16'd21, 16'd5},   {4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, 16'd20, NONE},
        '{1'b0, 1'b1, {16'd30, 16'd0, 16'd20, 16'd19, 16'd0, 16'd0},     {4'd5, 4'd0, 4'd3, 4'd0, 4'd0, 4'd0}, 16'd20, NONE},
        // pass C: zero fit, empty burst
        '{1'b1, 1'b0, {16'd80, 16'd70, 16'd0, 16'd55, 16'd60, 16'd50},   {4'd5, 4'd4, 4'd7, 4'd2, 4'd1, 4'd0}, 16'd0, 4'd7},
        '{1'b0, 1'b0, {16'd3, 16'd3, 16'd3, 16'd3, 16'd3, 16'd3},        {4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, 16'd0, 4'd7},
        '{1'b0, 1'b1, {16'd3, 16'd3, 16'd3, 16'd3, 16'd3, 16'd3},        {4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, 16'd0, 4'd7}
    };

    logic clk = 1'b0;
    logic rst;
    logic start, first_view, store_mode;
    logic [IDX_W-1:0] store_sel;
    logic [FIT_W-1:0] bus_fit;
    logic [NAME_W-1:0] bus_name;
    logic [NSRC-1:0] sel;
    logic [FIT_W-1:0] best_fit;
    logic [NAME_W-1:0] best_name;
    logic pulse, done;

    logic [5:0][FIT_W-1:0] src_fit;
    logic [5:0][NAME_W-1:0] src_name;

    int total = 0;
    int bad = 0;
    int pcount = 0;
    logic pclr = 1'b0;

    always #5 clk = ~clk;

    best_fit_search #(
        .FIT_W(FIT_W), .NAME_W(NAME_W), .NUM_LOC(NUM_LOC), .NUM_VIEWS(NUM_VIEWS)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .first_view_i(first_view),
        .store_mode_i(store_mode), .store_sel_i(store_sel),
        .bus_fit_i(bus_fit), .bus_name_i(bus_name),
        .src_sel_o(sel), .best_fit_o(best_fit), .best_name_o(best_name),
        .pulse_o(pulse), .done_o(done)
    );

    // result bus model
    always_comb begin
        bus_fit  = '0;
        bus_name = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel[i]) begin
                bus_fit  = src_fit[i];
                bus_name = src_name[i];
            end
        end
    end

    always @(negedge clk) begin
        if (pclr) pcount = 0;
        else if (pulse) pcount = pcount + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, req, int'(done), 1);
    endtask

    task automatic run_view(input vec_t v);
        int nsel;
        @(negedge clk);
        src_fit = v.fit;
        src_name = v.name;
        first_view = v.first;
        pclr = v.first;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pclr = 1'b0;
        // R7: done clears on start
        chk(done == 1'b0, "R7 done cleared by start", int'(done), 0);
        nsel = v.first ? NSRC : NSRC - 1;
        for (int k = 0; k < nsel; k++) begin
            int exp_idx;
            exp_idx = v.first ? k : k + 1;
            // R2 order, R5 source 0 skipped on later views
            chk(sel == NSRC'(1 << exp_idx), v.first ? "R2 select order" : "R5 select skips threshold",
                int'(sel), 1 << exp_idx);
            @(negedge clk);
        end
        // R3 R4 R5 kept result after this view
        chk(best_fit == v.exp_fit, "R4 best fit after view", int'(best_fit), int'(v.exp_fit));
        chk(best_name == v.exp_name, v.exp_name == NONE ? "R3 threshold name code" : "R4 best name after view",
            int'(best_name), int'(v.exp_name));
        if (v.last) begin
            wait_done("R7 done after final view");
            chk(pcount == int'(v.exp_fit), "R6 pulse count equals fit", pcount, int'(v.exp_fit));
        end else begin
            repeat (2) @(negedge clk);
            chk(pcount == 0 && done == 1'b0, "R6 no burst before final view", pcount, 0);
        end
    endtask

    task automatic run_store(input int loc, input int f, input int nm);
        @(negedge clk);
        store_mode = 1'b1;
        store_sel = IDX_W'(loc);
        src_fit[loc] = FIT_W'(f);
        src_name[loc] = NAME_W'(nm);
        @(negedge clk);
        chk(sel == NSRC'(1 << loc), "R8 store select", int'(sel), 1 << loc);
        pclr = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pclr = 1'b0;
        store_mode = 1'b0;
        chk(best_fit == FIT_W'(f), "R8 store fit captured", int'(best_fit), f);
        chk(best_name == NAME_W'(nm), "R8 store name captured", int'(best_name), nm);
        wait_done("R8 store done");
        chk(pcount == f, "R8 store pulse count", pcount, f);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        first_view = 1'b0;
        store_mode = 1'b0;
        store_sel = '0;
        src_fit = '0;
        src_name = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(sel == '0, "R1 select idle", int'(sel), 0);
        chk(pulse == 1'b0, "R1 pulse idle", int'(pulse), 0);
        chk(done == 1'b0, "R1 done idle", int'(done), 0);
        chk(best_fit == '0, "R1 best fit", int'(best_fit), 0);
        chk(best_name == '0, "R1 best name", int'(best_name), 0);

        for (int i = 0; i < NVEC; i++) run_view(VEC[i]);

        // R7: done stays high while idle
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R7 done held while idle", int'(done), 1);

        // R8: direct capture, then a larger fit with zero name still captured
        run_store(4, 37, 9);
        run_store(2, 300, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule